// File: doc/BRIEF.md
# Chainable Serial-Programmed Level Register Bank

This block holds four 8-bit level registers that a host programs over a three-wire serial link made of an active-low select, a serial clock and a data line. The host lowers the select and clocks in a 10-bit word. The first two bits of the word name the target channel and the next eight bits give the new level. When the select returns high, the word held at that moment is decoded and written into the named register. A serial data output repeats the input stream delayed by exactly ten bits. Several banks can therefore be wired output-to-input and loaded from one long frame while the select is held low for the whole frame.

The serial pins are asynchronous to the block clock. They pass through a synchronizer and are edge-detected in the block clock domain, so the serial clock must be several times slower than `clk`. An active-low reset returns every register to midscale (0x80) and clears the serial output bit. An active-low shutdown input parks the serial output at logic high and raises a shutdown status flag. The register contents are kept during shutdown.

Top module: `serial_latch_bank`

## Requirements
- R1: While and after `rst_n` is low, every channel of `level_o` reads 0x80, `ser_dout` reads 0 and `shut_o` reads 0, provided `shdn_n` is high.
- R2: While `ser_csn` is low, each rising `ser_clk` edge shifts `ser_din` into a 10-bit word, first bit first. On the rising edge of `ser_csn`, bits 9:8 of the word select the channel and bits 7:0 become its level. Address 00 selects channel 0 (`level_o[7:0]`), 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3 (`level_o[31:24]`).
- R3: A load changes only the addressed channel. All other channels keep their values.
- R4: `ser_clk` edges while `ser_csn` is high do not alter the held word.
- R5: A select pulse with fewer than ten clocks loads the current word, which is the previous word shifted left by the number of new bits, keeping the low ten bits. A pulse with no clocks reloads the word unchanged.
- R6: `ser_dout` presents the bit that entered ten `ser_clk` rising edges earlier. A 20-bit frame into two chained banks leaves the first 10 bits in the far bank and the last 10 bits in the near bank.
- R7: `ser_dout` changes only after a falling `ser_clk` edge, never at the rising edge.
- R8: While `ser_csn` is high, `ser_dout` holds its value through any `ser_clk` activity.
- R9: While `shdn_n` is low, `shut_o` is 1 and `ser_dout` is 1, and all levels are kept.
- R10: Reset is asynchronous and wins over a load whose select rises in the same cycle. No level other than 0x80 survives.
- R11: Four words, each closed by its own select rising edge, program all four channels independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset to midscale |
| ser_clk | input | 1 | Serial shift clock, idle low |
| ser_csn | input | 1 | Active-low select; its rising edge loads a channel |
| ser_din | input | 1 | Serial data in, first bit first |
| shdn_n | input | 1 | Active-low shutdown |
| ser_dout | output | 1 | Serial data out, ten bits behind `ser_din`, high in shutdown |
| shut_o | output | 1 | Shutdown status |
| level_o | output | 32 | Four 8-bit levels, channel 0 in the low byte |

## Verification
The assertions rely on each serial pin holding steady for several block clocks, so every synchronized edge is seen exactly once and a shift, an output update and a load never fall in the same cycle. The bench keeps each serial clock phase at eight block clocks. It changes data and select only while the serial clock is low, and it lets a load settle for more than twenty block clocks. Reset and shutdown are driven at the falling edge of `clk`. The select-versus-reset collision is the only stimulus that changes two inputs in the same cycle.

// File: rtl/slb_pkg.sv
package slb_pkg;

    localparam int SLB_NUM_CH  = 4;
    localparam int SLB_DATA_W  = 8;
    localparam int SLB_SYNC    = 2;

    // bit positions of the serial pins inside the synchronizer vector
    localparam int PIN_SCLK = 0;
    localparam int PIN_CSN  = 1;
    localparam int PIN_DIN  = 2;
    localparam int PIN_SHDN = 3;
    localparam int PIN_CNT  = 4;

    // idle levels: clock low, select high, data low, shutdown released
    localparam logic [PIN_CNT-1:0] PIN_IDLE = 4'b1010;

    typedef struct packed {
        logic off;
    } slb_out_t;

endpackage

// File: rtl/slb_sync.sv
module slb_sync #(
    parameter int                WIDTH  = 4,
    parameter int                STAGES = 2,
    parameter logic [WIDTH-1:0]  IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_d [STAGES];
            logic [WIDTH-1:0] stage_q [STAGES];

            always_comb begin
                stage_d[0] = d_i;
                for (int s = 1; s < STAGES; s++) begin
                    stage_d[s] = stage_q[s-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < STAGES; s++) begin
                        stage_q[s] <= IDLE;
                    end
                end else begin
                    for (int s = 0; s < STAGES; s++) begin
                        stage_q[s] <= stage_d[s];
                    end
                end
            end

            assign q_o = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/slb_shifter.sv
module slb_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o,
    output logic              sdo_o,
    output logic              fall_o
);

    typedef struct packed {
        logic              sclk_prev;
        logic              csn_prev;
        logic [WORD_W-1:0] sr;
        logic              sdo;
    } shift_t;

    shift_t st_d, st_q;
    logic   rise;
    logic   fall;

    always_comb begin
        rise = sclk_i & ~st_q.sclk_prev;
        fall = ~sclk_i & st_q.sclk_prev;

        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        st_d.csn_prev  = csn_i;

        if (!csn_i && rise) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], din_i};
        end
        // output bit moves on the falling edge so a following bank
        // samples a settled value on its next rising edge
        if (!csn_i && fall) begin
            st_d.sdo = st_q.sr[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.csn_prev  <= 1'b1;
            st_q.sr        <= '0;
            st_q.sdo       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.sr;
    assign load_o = csn_i & ~st_q.csn_prev;
    assign sdo_o  = st_q.sdo;
    assign fall_o = fall;

endmodule

// File: rtl/slb_latches.sv
module slb_latches #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic [NUM_CH*DATA_W-1:0] level_o
);

    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic [DATA_W-1:0] lvl_d, lvl_q;

            always_comb begin
                lvl_d = lvl_q;
                if (load_i && (addr_i == ADDR_W'(c))) begin
                    lvl_d = data_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q <= MID;
                end else begin
                    lvl_q <= lvl_d;
                end
            end

            assign level_o[c*DATA_W +: DATA_W] = lvl_q;
        end
    endgenerate

endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
    import slb_pkg::*;
#(
    parameter int NUM_CH      = SLB_NUM_CH,
    parameter int DATA_W      = SLB_DATA_W,
    parameter int SYNC_STAGES = SLB_SYNC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_csn,
    input  logic                     ser_din,
    input  logic                     shdn_n,
    output logic                     ser_dout,
    output logic                     shut_o,
    output logic [NUM_CH*DATA_W-1:0] level_o
);

    localparam int ADDR_W = $clog2(NUM_CH);
    localparam int WORD_W = ADDR_W + DATA_W;

    logic [PIN_CNT-1:0] pins_raw, pins_s;
    logic               sclk_s, csn_s, din_s, shdn_s;
    logic [WORD_W-1:0]  word;
    logic               load_en;
    logic               sdo_bit;
    logic               sclk_fall;
    slb_out_t           out_d, out_q;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = ser_clk;
        pins_raw[PIN_CSN]  = ser_csn;
        pins_raw[PIN_DIN]  = ser_din;
        pins_raw[PIN_SHDN] = shdn_n;
    end

    slb_sync #(
        .WIDTH  (PIN_CNT),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign sclk_s = pins_s[PIN_SCLK];
    assign csn_s  = pins_s[PIN_CSN];
    assign din_s  = pins_s[PIN_DIN];
    assign shdn_s = pins_s[PIN_SHDN];

    slb_shifter #(
        .WORD_W (WORD_W)
    ) i_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_s),
        .csn_i  (csn_s),
        .din_i  (din_s),
        .word_o (word),
        .load_o (load_en),
        .sdo_o  (sdo_bit),
        .fall_o (sclk_fall)
    );

    slb_latches #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_latches (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_en),
        .addr_i  (word[WORD_W-1:DATA_W]),
        .data_i  (word[DATA_W-1:0]),
        .level_o (level_o)
    );

    always_comb begin
        out_d     = out_q;
        out_d.off = ~shdn_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign shut_o   = out_q.off;
    assign ser_dout = sdo_bit | out_q.off;

endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH*DATA_W-1:0] level_o,
    input logic                     ser_dout,
    input logic                     shut_o,
    input logic                     load_en,
    input logic                     sdo_bit,
    input logic                     sclk_fall,
    input logic                     csn_s
);

    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic [NUM_CH*DATA_W-1:0] lvl_prev_q;
    logic [NUM_CH-1:0]        chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev_q <= {NUM_CH{MID}};
        end else begin
            lvl_prev_q <= level_o;
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            chg[c] = level_o[c*DATA_W +: DATA_W] != lvl_prev_q[c*DATA_W +: DATA_W];
        end
    end

    a_r1_midscale_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (level_o == {NUM_CH{MID}}));

    a_r2_change_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |-> $past(load_en));

    a_r3_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    a_r7_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_bit) |-> $past(sclk_fall));

    a_r8_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csn_s) |-> $stable(sdo_bit));

    a_r9_shutdown_high: assert property (@(posedge clk) disable iff (!rst_n)
        shut_o |-> ser_dout);

endmodule

bind serial_latch_bank slb_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) i_slb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_o   (level_o),
    .ser_dout  (ser_dout),
    .shut_o    (shut_o),
    .load_en   (load_en),
    .sdo_bit   (sdo_bit),
    .sclk_fall (sclk_fall),
    .csn_s     (csn_s)
);

// File: tb/test_serial_latch_bank.sv
module test_serial_latch_bank;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_csn = 1'b1;
    logic        ser_din = 1'b0;
    logic        shdn_n = 1'b1;
    logic        dout_a, dout_b;
    logic        shut_a, shut_b;
    logic [31:0] level_a, level_b;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    serial_latch_bank i_serial_latch_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_csn  (ser_csn),
        .ser_din  (ser_din),
        .shdn_n   (shdn_n),
        .ser_dout (dout_a),
        .shut_o   (shut_a),
        .level_o  (level_a)
    );

    serial_latch_bank i_serial_latch_bank_far (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_csn  (ser_csn),
        .ser_din  (dout_a),
        .shdn_n   (shdn_n),
        .ser_dout (dout_b),
        .shut_o   (shut_b),
        .level_o  (level_b)
    );

    function automatic int lv_a(int ch);
        return int'(level_a[ch*8 +: 8]);
    endfunction

    function automatic int lv_b(int ch);
        return int'(level_b[ch*8 +: 8]);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        @(negedge clk);
        ser_din = b;
        wait_half();
        ser_clk = 1'b1;
        wait_half();
        ser_clk = 1'b0;
    endtask

    task automatic send_word(logic [9:0] w);
        @(negedge clk);
        ser_csn = 1'b0;
        wait_half();
        for (int i = 9; i >= 0; i--) shift_bit(w[i]);
        wait_half();
        ser_csn = 1'b1;
        wait_half();
        wait_half();
        wait_half();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        for (int c = 0; c < 4; c++) begin
            chk("R1 level a", lv_a(c), 'h80);
            chk("R1 level b", lv_b(c), 'h80);
        end
        chk("R1 dout", int'(dout_a), 0);
        chk("R1 shut", int'(shut_a), 0);
    endtask

    // far bank gets addr 10 data C3, near bank gets addr 01 data 5A
    task automatic t_chain();
        logic [19:0] frame;
        frame = {2'b10, 8'hC3, 2'b01, 8'h5A};
        @(negedge clk);
        ser_csn = 1'b0;
        wait_half();
        for (int i = 19; i >= 0; i--) begin
            @(negedge clk);
            ser_din = frame[i];
            wait_half();
            ser_clk = 1'b1;
            wait_half();
            if (i == 10) chk("R7 dout before fall", int'(dout_a), 0);
            ser_clk = 1'b0;
            wait_half();
            if (i == 10) chk("R7 dout after fall", int'(dout_a), 1);
            if (i == 10) chk("R6 dout first bit", int'(dout_a), int'(frame[19]));
        end
        ser_csn = 1'b1;
        repeat (3) wait_half();
        chk("R6 near ch1", lv_a(1), 'h5A);
        chk("R6 far ch2", lv_b(2), 'hC3);
        chk("R3 near ch2", lv_a(2), 'h80);
        chk("R3 far ch1", lv_b(1), 'h80);
        chk("R3 near ch0", lv_a(0), 'h80);
    endtask

    task automatic t_all_four();
        send_word({2'b00, 8'h11});
        chk("R2 ch0", lv_a(0), 'h11);
        chk("R3 ch1 kept", lv_a(1), 'h5A);
        chk("R3 ch3 kept", lv_a(3), 'h80);
        send_word({2'b01, 8'h22});
        send_word({2'b10, 8'h33});
        send_word({2'b11, 8'h44});
        chk("R11 ch0", lv_a(0), 'h11);
        chk("R11 ch1", lv_a(1), 'h22);
        chk("R11 ch2", lv_a(2), 'h33);
        chk("R11 ch3", lv_a(3), 'h44);
    endtask

    task automatic t_csn_high();
        logic [9:0] y;
        logic       held;
        y = {2'b10, 8'hEE};
        held = dout_a;
        for (int i = 9; i >= 0; i--) begin
            shift_bit(y[i]);
            wait_half();
            chk("R8 dout held", int'(dout_a), int'(held));
        end
        @(negedge clk);
        ser_csn = 1'b0;
        wait_half();
        ser_csn = 1'b1;
        repeat (3) wait_half();
        chk("R4 ch2 untouched", lv_a(2), 'h33);
        chk("R4 ch3 reload", lv_a(3), 'h44);
    endtask

    task automatic t_short();
        logic [9:0] cur;
        logic [3:0] nib;
        logic [9:0] exp_w;
        cur = {2'b11, 8'h44};
        nib = 4'b0101;
        exp_w = 10'({cur, nib});
        @(negedge clk);
        ser_csn = 1'b0;
        wait_half();
        for (int i = 3; i >= 0; i--) shift_bit(nib[i]);
        wait_half();
        ser_csn = 1'b1;
        repeat (3) wait_half();
        chk("R5 short target", lv_a(int'(exp_w[9:8])), int'(exp_w[7:0]));
        chk("R5 ch3 kept", lv_a(3), 'h44);
    endtask

    task automatic t_shutdown();
        @(negedge clk);
        shdn_n = 1'b0;
        wait_half();
        chk("R9 shut", int'(shut_a), 1);
        chk("R9 dout high", int'(dout_a), 1);
        chk("R9 ch1 kept", lv_a(1), 'h22);
        chk("R9 ch2 kept", lv_a(2), 'h33);
        @(negedge clk);
        shdn_n = 1'b1;
        wait_half();
        chk("R9 shut released", int'(shut_a), 0);
    endtask

    task automatic t_reset_prio();
        logic [9:0] w;
        w = {2'b01, 8'h99};
        @(negedge clk);
        ser_csn = 1'b0;
        wait_half();
        for (int i = 9; i >= 0; i--) shift_bit(w[i]);
        wait_half();
        ser_csn = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 async midscale", lv_a(3), 'h80);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) wait_half();
        chk("R10 ch1 not loaded", lv_a(1), 'h80);
        t_reset_state();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL all: watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_chain();
        t_all_four();
        t_csn_high();
        t_short();
        t_shutdown();
        t_reset_prio();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule